// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for each beat of a short burst into a synchronous memory. A load command captures a full starting address from outside. Each continue command then steps only the lowest address field to the next beat. The upper part of the address stays frozen, and the low field wraps inside its own width.

Two beat orders are available, and a static select input chooses between them. The counting order adds the beat number to the starting offset, modulo the field size. The interleaved order combines the starting offset with the beat number by XOR. A clock enable suspends the sequencer: while it is low, every register keeps its value.

The address and the beat index are both registered. After each enabled edge they present the state that edge produced.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, the address output and the beat index are both zero.
- R2: On an edge with the enable and load both high, the address output becomes the external address and the beat index becomes zero.
- R3: With the order select low (linear), the low two address bits on beat k equal the start's low bits plus k, modulo 4. A start of 2 gives 2, 3, 0, 1.
- R4: With the order select high (interleaved), the low two address bits on beat k equal the start's low bits XOR k. A start of 1 gives 1, 0, 3, 2.
- R5: After the fourth beat, one more advance returns the low bits to the start value and the beat index to zero.
- R6: During a burst the address bits above bit 1 never change, and no carry leaves the two-bit field.
- R7: While the enable is low, the address output and the beat index hold their values whatever load and advance do.
- R8: When load and advance are both high on an enabled edge, the load takes effect and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Clock enable; low suspends all state |
| start_ld | input | 1 | Capture the external address and begin a burst |
| beat_adv | input | 1 | Advance to the next beat |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved (held static) |
| ext_addr | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Two functions can arrive on the same edge. The first pair is load and advance: the bench raises both in the middle of a running burst. The pass condition is that the address equals the fresh external address with beat index zero, not the next beat of the old burst. The second pair is suspend with load or advance: the bench drives commands with the enable low and checks that both outputs stay unchanged on the following cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } beat_order_e;

endpackage

// File: rtl/burst_offset_calc.sv
module burst_offset_calc
    import burst_addr_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_lo,
    input  logic [LOW_W-1:0] beat,
    input  logic             order_sel,
    output logic [LOW_W-1:0] lo_out
);

    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] ilv_lo;

    // The sum is kept LOW_W bits wide so that no carry leaves the field.
    assign lin_lo = start_lo + beat;
    assign ilv_lo = start_lo ^ beat;

    always_comb begin
        if (beat_order_e'(order_sel) == ORD_INTERLEAVE) lo_out = ilv_lo;
        else                                            lo_out = lin_lo;
    end

endmodule

// File: rtl/burst_beat_next.sv
module burst_beat_next #(
    parameter int LOW_W = 2
) (
    input  logic             step_en,
    input  logic             start_ld,
    input  logic             beat_adv,
    input  logic [LOW_W-1:0] beat_q,
    output logic [LOW_W-1:0] beat_d
);

    always_comb begin
        beat_d = beat_q;
        if (step_en) begin
            if (start_ld)      beat_d = '0;
            else if (beat_adv) beat_d = beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              start_ld,
    input  logic              beat_adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_idx
);

    localparam int LOW_W  = 2;
    localparam int HIGH_W = ADDR_W - LOW_W;

    typedef struct packed {
        logic [HIGH_W-1:0] upper;
        logic [LOW_W-1:0]  start;
        logic [LOW_W-1:0]  beat;
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             take_ld;
    logic [LOW_W-1:0] start_nx;
    logic [LOW_W-1:0] beat_nx;
    logic [LOW_W-1:0] lo_nx;

    assign take_ld  = step_en && start_ld;
    assign start_nx = take_ld ? ext_addr[LOW_W-1:0] : st_q.start;

    burst_beat_next #(.LOW_W(LOW_W)) u_beat (
        .step_en  (step_en),
        .start_ld (start_ld),
        .beat_adv (beat_adv),
        .beat_q   (st_q.beat),
        .beat_d   (beat_nx)
    );

    burst_offset_calc #(.LOW_W(LOW_W)) u_offs (
        .start_lo (start_nx),
        .beat     (beat_nx),
        .order_sel(order_sel),
        .lo_out   (lo_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = start_nx;
        st_d.beat  = beat_nx;
        if (take_ld) st_d.upper = ext_addr[ADDR_W-1:LOW_W];
        if (step_en) st_d.addr  = {st_d.upper, lo_nx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_out = st_q.addr;
    assign beat_idx = st_q.beat;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              start_ld,
    input logic              beat_adv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (addr_out == '0 && beat_idx == 2'd0)));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && start_ld) |=> (addr_out == $past(ext_addr) && beat_idx == 2'd0));

    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && beat_adv && !start_ld) |=> (beat_idx == 2'($past(beat_idx) + 2'd1)));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_en && start_ld) |=> $stable(addr_out[ADDR_W-1:2]));

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(addr_out) && $stable(beat_idx)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .start_ld(start_ld),
    .beat_adv(beat_adv),
    .ext_addr(ext_addr),
    .addr_out(addr_out),
    .beat_idx(beat_idx)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_en = 1'b0;
    logic              start_ld = 1'b0;
    logic              beat_adv = 1'b0;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .start_ld(start_ld),
        .beat_adv(beat_adv), .order_sel(order_sel), .ext_addr(ext_addr),
        .addr_out(addr_out), .beat_idx(beat_idx)
    );

    function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] k, logic ilv);
        logic [2:0] sum;
        sum = {1'b0, s} + {1'b0, k};
        return ilv ? (s ^ k) : sum[1:0];
    endfunction

    task automatic expect_out(string tag, logic [ADDR_W-1:0] ea, logic [1:0] eb);
        total++;
        if (addr_out !== ea || beat_idx !== eb) begin
            bad++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, addr_out, beat_idx, ea, eb);
        end
    endtask

    task automatic cycle(logic en, logic ld, logic adv, logic [ADDR_W-1:0] a);
        step_en = en; start_ld = ld; beat_adv = adv; ext_addr = a;
        @(posedge clk);
        @(negedge clk);
        step_en = 1'b0; start_ld = 1'b0; beat_adv = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1 during reset", '0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after release", '0, 2'd0);
    endtask

    task automatic t_burst(string tag, logic ilv, logic [ADDR_W-1:0] a);
        order_sel = ilv;
        cycle(1'b1, 1'b1, 1'b0, a);
        expect_out({"R2 load ", tag}, a, 2'd0);
        for (int k = 1; k < 4; k++) begin
            cycle(1'b1, 1'b0, 1'b1, '0);
            expect_out({tag, " R6 beat"},
                       {a[ADDR_W-1:2], exp_lo(a[1:0], 2'(k), ilv)}, 2'(k));
        end
        cycle(1'b1, 1'b0, 1'b1, '0);
        expect_out({"R5 wrap ", tag}, a, 2'd0);
    endtask

    task automatic t_suspend();
        logic [ADDR_W-1:0] a;
        order_sel = 1'b0;
        a = 20'h5A5A6;
        cycle(1'b1, 1'b1, 1'b0, a);
        cycle(1'b1, 1'b0, 1'b1, '0);
        expect_out("R7 setup", {a[ADDR_W-1:2], 2'd3}, 2'd1);
        cycle(1'b0, 1'b0, 1'b1, '0);
        expect_out("R7 adv ignored", {a[ADDR_W-1:2], 2'd3}, 2'd1);
        cycle(1'b0, 1'b1, 1'b0, 20'hFFFFF);
        expect_out("R7 load ignored", {a[ADDR_W-1:2], 2'd3}, 2'd1);
        cycle(1'b1, 1'b0, 1'b1, '0);
        expect_out("R7 resume", {a[ADDR_W-1:2], 2'd0}, 2'd2);
    endtask

    task automatic t_collide();
        logic [ADDR_W-1:0] a;
        order_sel = 1'b1;
        cycle(1'b1, 1'b1, 1'b0, 20'h11111);
        cycle(1'b1, 1'b0, 1'b1, '0);
        a = 20'hABCDE;
        cycle(1'b1, 1'b1, 1'b1, a);
        expect_out("R8 load wins", a, 2'd0);
        cycle(1'b1, 1'b0, 1'b1, '0);
        expect_out("R8 then step R4", {a[ADDR_W-1:2], 2'b11}, 2'd1);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst("R3 linear", 1'b0, 20'h00002);
        t_burst("R4 interleave", 1'b1, 20'h00001);
        t_burst("R3 linear carry", 1'b0, 20'h3FFFF);
        t_burst("R4 interleave top", 1'b1, 20'hFFFFE);
        t_suspend();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule